// File: doc/BRIEF.md
# CAN Peripheral Register Access Guard

This block watches the host register bus of a two-channel CAN peripheral and flags accesses that break the peripheral's access rules. It does not store the peripheral's registers. It keeps the global operation-mode bit, two sticky pending flags and two interrupt pulse lines.

Every access is classified against an address map given by parameters:

- a control word that holds the operation-mode bit;
- two acknowledge words, one for each pending flag;
- an unused region;
- one register window per channel;
- a temporary buffer region.

Whether an access is illegal depends on the address and also on the global operation mode, the forced-shutdown enable bit and the initialization state of every channel.

The configuration-fault source (source 1) reports two things: accesses into unused space, and refused attempts to leave operation mode. The write-protect source (source 2) reports writes that the current operation mode forbids. Software clears each pending flag through its own acknowledge address.

Top module: `canbus_access_guard`

## Requirements
- R1: After synchronous reset, `op_mode`, `pend_cfg`, `pend_wp`, `irq_cfg` and `irq_wp` are all 0.
- R2: A read or a write to any address in the unused region (default 0x010 to 0x0FF) sets `pend_cfg` on the following clock.
- R3: A write to the control address (default 0x000) loads `op_mode` from `bus_wbit` on the following clock whenever the write is not refused. A clearing write is allowed when `fsd_en` is 1 or when every bit of `chan_init` is 1.
- R4: While `op_mode` is 1, a control write with `bus_wbit` 0 is refused when `fsd_en` is 0 and at least one bit of `chan_init` is 0. A refused write leaves `op_mode` at 1 and sets `pend_cfg`.
- R5: While `op_mode` is 0, a write anywhere in either channel window sets `pend_wp`. The default windows are 0x100 to 0x1FF for channel 0 and 0x200 to 0x2FF for channel 1.
- R6: While `op_mode` is 1, a write to the temporary buffer region (default 0x300 to 0x37F) sets `pend_wp`.
- R7: Reads of the channel windows or of the buffer region never set `pend_wp`. The following writes leave `pend_wp` unchanged: a channel write while `op_mode` is 1, and a buffer write while `op_mode` is 0.
- R8: Each pending flag stays set until a write with `bus_wbit` 1 reaches its own acknowledge address (0x004 for `pend_cfg`, 0x008 for `pend_wp`). A write there with `bus_wbit` 0 has no effect, and clearing one flag leaves the other unchanged.
- R9: `irq_cfg` and `irq_wp` are high for exactly the one clock that follows each access violating that source, and low otherwise. Every source matched by an access is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wbit | input | 1 | Write data bit 0 |
| fsd_en | input | 1 | Forced-shutdown enable |
| chan_init | input | NCH | Per-channel initialized status, 1 = initialized |
| op_mode | output | 1 | Global operation-mode bit |
| pend_cfg | output | 1 | Configuration-fault pending flag |
| pend_wp | output | 1 | Write-protect pending flag |
| irq_cfg | output | 1 | Configuration-fault interrupt pulse |
| irq_wp | output | 1 | Write-protect interrupt pulse |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `fsd_en` and `chan_init` hold steady through the cycle of an access, because the refusal decision samples them at that edge. The stimulus keeps to this by issuing one access per call and changing the status inputs only between accesses. The acknowledge and control writes always name a single address outside the violation regions.

// File: rtl/cag_pkg.sv
package cag_pkg;

  localparam int NSRC = 2;

  typedef enum int {
    SRC_CFG = 0,
    SRC_WP  = 1
  } src_e;

  typedef struct packed {
    logic unused;
    logic chan;
    logic tbuf;
    logic ctrl;
    logic clr_cfg;
    logic clr_wp;
  } hit_t;

  function automatic logic in_span(input int a, input int lo, input int hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/cag_decode.sv
module cag_decode
  import cag_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int ADDR_W       = 12,
  parameter int CTRL_ADDR    = 'h000,
  parameter int CLR_CFG_ADDR = 'h004,
  parameter int CLR_WP_ADDR  = 'h008,
  parameter int UNUSED_LO    = 'h010,
  parameter int UNUSED_HI    = 'h0FF,
  parameter int CH_BASE      = 'h100,
  parameter int CH_STRIDE    = 'h100,
  parameter int CH_SIZE      = 'h100,
  parameter int TBUF_LO      = 'h300,
  parameter int TBUF_HI      = 'h37F
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);

  int a_i;
  logic [NCH-1:0] ch_hit;

  assign a_i = int'(addr);

  // one window comparator per channel
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int LO = CH_BASE + g * CH_STRIDE;
      localparam int HI = LO + CH_SIZE - 1;
      assign ch_hit[g] = in_span(a_i, LO, HI);
    end
  endgenerate

  always_comb begin
    hit         = '0;
    hit.unused  = in_span(a_i, UNUSED_LO, UNUSED_HI);
    hit.chan    = |ch_hit;
    hit.tbuf    = in_span(a_i, TBUF_LO, TBUF_HI);
    hit.ctrl    = (a_i == CTRL_ADDR);
    hit.clr_cfg = (a_i == CLR_CFG_ADDR);
    hit.clr_wp  = (a_i == CLR_WP_ADDR);
  end

endmodule

// File: rtl/cag_rules.sv
module cag_rules
  import cag_pkg::*;
#(
  parameter int NCH = 2
) (
  input  hit_t           hit,
  input  logic           rd,
  input  logic           wr,
  input  logic           wbit,
  input  logic           op_mode,
  input  logic           fsd_en,
  input  logic [NCH-1:0] chan_init,
  output logic           viol_cfg,
  output logic           viol_wp,
  output logic           clr_cfg,
  output logic           clr_wp,
  output logic           op_load,
  output logic           op_val
);

  logic all_ready;
  logic clr_try;
  logic refuse;

  always_comb begin
    all_ready = &chan_init;
    clr_try   = wr & hit.ctrl & ~wbit & op_mode;
    refuse    = clr_try & ~fsd_en & ~all_ready;

    viol_cfg  = ((rd | wr) & hit.unused) | refuse;
    viol_wp   = wr & ((hit.chan & ~op_mode) | (hit.tbuf & op_mode));

    clr_cfg   = wr & hit.clr_cfg & wbit;
    clr_wp    = wr & hit.clr_wp & wbit;

    op_load   = wr & hit.ctrl & ~refuse;
    op_val    = wbit;
  end

endmodule

// File: rtl/cag_flag.sv
module cag_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pend,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= set | (pend & ~clr);
      irq  <= set;
    end
  end

endmodule

// File: rtl/canbus_access_guard.sv
module canbus_access_guard
  import cag_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int ADDR_W       = 12,
  parameter int CTRL_ADDR    = 'h000,
  parameter int CLR_CFG_ADDR = 'h004,
  parameter int CLR_WP_ADDR  = 'h008,
  parameter int UNUSED_LO    = 'h010,
  parameter int UNUSED_HI    = 'h0FF,
  parameter int CH_BASE      = 'h100,
  parameter int CH_STRIDE    = 'h100,
  parameter int CH_SIZE      = 'h100,
  parameter int TBUF_LO      = 'h300,
  parameter int TBUF_HI      = 'h37F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_wbit,
  input  logic              fsd_en,
  input  logic [NCH-1:0]    chan_init,
  output logic              op_mode,
  output logic              pend_cfg,
  output logic              pend_wp,
  output logic              irq_cfg,
  output logic              irq_wp
);

  hit_t hit;
  logic viol_cfg, viol_wp, clr_cfg, clr_wp, op_load, op_val;
  logic [NSRC-1:0] set_v, clr_v, pend_v, irq_v;

  cag_decode #(
    .NCH(NCH), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .CLR_CFG_ADDR(CLR_CFG_ADDR), .CLR_WP_ADDR(CLR_WP_ADDR),
    .UNUSED_LO(UNUSED_LO), .UNUSED_HI(UNUSED_HI),
    .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE), .CH_SIZE(CH_SIZE),
    .TBUF_LO(TBUF_LO), .TBUF_HI(TBUF_HI)
  ) u_decode (
    .addr(bus_addr),
    .hit (hit)
  );

  cag_rules #(.NCH(NCH)) u_rules (
    .hit      (hit),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .wbit     (bus_wbit),
    .op_mode  (op_mode),
    .fsd_en   (fsd_en),
    .chan_init(chan_init),
    .viol_cfg (viol_cfg),
    .viol_wp  (viol_wp),
    .clr_cfg  (clr_cfg),
    .clr_wp   (clr_wp),
    .op_load  (op_load),
    .op_val   (op_val)
  );

  // global operation-mode bit
  always_ff @(posedge clk) begin
    if (rst)          op_mode <= 1'b0;
    else if (op_load) op_mode <= op_val;
  end

  always_comb begin
    set_v          = '0;
    clr_v          = '0;
    set_v[SRC_CFG] = viol_cfg;
    set_v[SRC_WP]  = viol_wp;
    clr_v[SRC_CFG] = clr_cfg;
    clr_v[SRC_WP]  = clr_wp;
  end

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      cag_flag u_flag (
        .clk (clk),
        .rst (rst),
        .set (set_v[s]),
        .clr (clr_v[s]),
        .pend(pend_v[s]),
        .irq (irq_v[s])
      );
    end
  endgenerate

  assign pend_cfg = pend_v[SRC_CFG];
  assign pend_wp  = pend_v[SRC_WP];
  assign irq_cfg  = irq_v[SRC_CFG];
  assign irq_wp   = irq_v[SRC_WP];

endmodule

// File: rtl/canbus_access_guard_chk.sv
module canbus_access_guard_chk #(
  parameter int NCH          = 2,
  parameter int ADDR_W       = 12,
  parameter int CTRL_ADDR    = 'h000,
  parameter int CLR_CFG_ADDR = 'h004,
  parameter int CLR_WP_ADDR  = 'h008,
  parameter int UNUSED_LO    = 'h010,
  parameter int UNUSED_HI    = 'h0FF,
  parameter int CH_BASE      = 'h100,
  parameter int CH_STRIDE    = 'h100,
  parameter int CH_SIZE      = 'h100,
  parameter int TBUF_LO      = 'h300,
  parameter int TBUF_HI      = 'h37F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_wbit,
  input logic              fsd_en,
  input logic [NCH-1:0]    chan_init,
  input logic              op_mode,
  input logic              pend_cfg,
  input logic              pend_wp,
  input logic              irq_cfg,
  input logic              irq_wp
);

  int a;
  logic in_unused, in_chan, in_tbuf, at_ctrl, ack_cfg, ack_wp;

  assign a         = int'(bus_addr);
  assign in_unused = (a >= UNUSED_LO) && (a <= UNUSED_HI);
  assign in_chan   = (a >= CH_BASE) && (a < CH_BASE + NCH * CH_STRIDE)
                     && (((a - CH_BASE) % CH_STRIDE) < CH_SIZE);
  assign in_tbuf   = (a >= TBUF_LO) && (a <= TBUF_HI);
  assign at_ctrl   = (a == CTRL_ADDR);
  assign ack_cfg   = bus_wr && bus_wbit && (a == CLR_CFG_ADDR);
  assign ack_wp    = bus_wr && bus_wbit && (a == CLR_WP_ADDR);

  // R2
  unused_access_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && in_unused) |=> pend_cfg);

  // R3
  allowed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_ctrl && !bus_wbit && (fsd_en || (&chan_init))) |=> !op_mode);

  // R4
  refused_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_ctrl && !bus_wbit && op_mode && !fsd_en && !(&chan_init))
      |=> (op_mode && pend_cfg));

  // R5
  chan_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_chan && !op_mode) |=> pend_wp);

  // R6
  tbuf_write_active_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_tbuf && op_mode) |=> pend_wp);

  // R7
  read_no_wp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> !irq_wp);

  // R8
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_cfg && !ack_cfg) |=> pend_cfg);

  // R8
  wp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_wp && !ack_wp) |=> pend_wp);

  // R9
  irq_cfg_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_cfg |-> pend_cfg);

  // R9
  irq_wp_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wp |-> pend_wp);

endmodule

bind canbus_access_guard canbus_access_guard_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .CLR_CFG_ADDR(CLR_CFG_ADDR), .CLR_WP_ADDR(CLR_WP_ADDR),
  .UNUSED_LO(UNUSED_LO), .UNUSED_HI(UNUSED_HI),
  .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE), .CH_SIZE(CH_SIZE),
  .TBUF_LO(TBUF_LO), .TBUF_HI(TBUF_HI)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wbit(bus_wbit), .fsd_en(fsd_en),
  .chan_init(chan_init), .op_mode(op_mode), .pend_cfg(pend_cfg),
  .pend_wp(pend_wp), .irq_cfg(irq_cfg), .irq_wp(irq_wp)
);

// File: tb/canbus_access_guard_test.sv
module canbus_access_guard_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_rd, bus_wr, bus_wbit, fsd_en;
  logic [1:0]  chan_init;
  logic        op_mode, pend_cfg, pend_wp, irq_cfg, irq_wp;

  always #5 clk = ~clk;

  canbus_access_guard uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wbit(bus_wbit), .fsd_en(fsd_en),
    .chan_init(chan_init), .op_mode(op_mode), .pend_cfg(pend_cfg),
    .pend_wp(pend_wp), .irq_cfg(irq_cfg), .irq_wp(irq_wp)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_op, m_pc, m_pw, m_ic, m_iw;

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "op_mode",  op_mode,  m_op);
    chk(tag, "pend_cfg", pend_cfg, m_pc);
    chk(tag, "pend_wp",  pend_wp,  m_pw);
    chk(tag, "irq_cfg",  irq_cfg,  m_ic);
    chk(tag, "irq_wp",   irq_wp,   m_iw);
  endtask

  // behavioural reference, evaluated with the inputs present at the edge
  task automatic model_edge();
    int  a;
    bit  acc, unused, chan, tbuf, refuse, v1, v2;
    a      = int'(bus_addr);
    acc    = bus_rd || bus_wr;
    unused = (a >= 'h010) && (a <= 'h0FF);
    chan   = (a >= 'h100) && (a <= 'h2FF);
    tbuf   = (a >= 'h300) && (a <= 'h37F);
    refuse = bus_wr && a == 0 && !bus_wbit && m_op && !fsd_en && (chan_init != 2'b11);
    v1     = (acc && unused) || refuse;
    v2     = bus_wr && ((chan && !m_op) || (tbuf && m_op));
    if (rst) begin
      m_op = 0; m_pc = 0; m_pw = 0; m_ic = 0; m_iw = 0;
    end else begin
      if (bus_wr && a == 0 && !refuse) m_op = bus_wbit;
      m_pc = v1 || (m_pc && !(bus_wr && a == 'h004 && bus_wbit));
      m_pw = v2 || (m_pw && !(bus_wr && a == 'h008 && bus_wbit));
      m_ic = v1;
      m_iw = v2;
    end
  endtask

  task automatic step(string tag, logic rd, logic wr, int a, logic wb);
    bus_rd   = rd;
    bus_wr   = wr;
    bus_addr = a[11:0];
    bus_wbit = wb;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wbit = 0;
    fsd_en = 0; chan_init = 2'b11;
    m_op = 0; m_pc = 0; m_pw = 0; m_ic = 0; m_iw = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 0;
    idle("R1");

    // unused region by read, then pulse drops
    step("R2", 1, 0, 'h050, 0);
    idle("R9");
    // acknowledge with bit 0 low: no effect; then real clear
    step("R8", 0, 1, 'h004, 0);
    step("R8", 0, 1, 'h004, 1);
    // unused region by write at the top edge
    step("R2", 0, 1, 'h0FF, 1);
    step("R8", 0, 1, 'h004, 1);

    // reads and buffer write while idle do not touch source 2
    step("R7", 1, 0, 'h100, 0);
    step("R7", 1, 0, 'h2FF, 0);
    step("R7", 0, 1, 'h300, 1);
    // channel writes while idle
    step("R5", 0, 1, 'h100, 1);
    step("R8", 0, 1, 'h008, 1);
    step("R5", 0, 1, 'h2A0, 0);
    step("R8", 0, 1, 'h008, 1);

    // enter operation mode
    step("R3", 0, 1, 'h000, 1);
    step("R7", 0, 1, 'h1F0, 1);
    step("R7", 1, 0, 'h37F, 0);
    step("R6", 0, 1, 'h37F, 0);
    idle("R9");

    // refused clear: channel 1 not ready, no forced shutdown
    chan_init = 2'b01;
    step("R4", 0, 1, 'h000, 0);
    // independence: clear source 2 only, source 1 stays
    step("R8", 0, 1, 'h008, 1);
    step("R8", 0, 1, 'h004, 1);
    // forced shutdown permits the clear
    fsd_en = 1;
    step("R3", 0, 1, 'h000, 0);
    // all channels ready permits the clear
    fsd_en = 0;
    chan_init = 2'b11;
    step("R3", 0, 1, 'h000, 1);
    step("R3", 0, 1, 'h000, 0);
    // clearing an already idle mode is not a violation
    chan_init = 2'b00;
    step("R4", 0, 1, 'h000, 0);
    idle("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule